// File: doc/BRIEF.md
# Synchronous burst SRAM datapath

A single-port synchronous static memory with a small array and 9-bit byte lanes. Each lane holds eight data bits plus one extra bit. Address, the three chip-select inputs, the burst controls, the write controls and the write data are all captured on the rising clock edge. A captured write goes into the array on the following edge. Each captured command is one of four kinds: a read, a write, a deselect, or nothing at all.

After a new address is loaded, advance strobes step a 2-bit burst counter. The counter stays inside the aligned four-word block and visits the words either in linear order or in interleaved order. A static input picks the read path. In flow-through mode the array output feeds the data pins directly. In pipelined mode the data passes through one more output register first.

Output turn-off follows a single-cycle deselect rule: the pins stop being driven right after a deselect is captured. An output enable gates the drivers asynchronously. A sleep input freezes every command and keeps the memory contents.

Top module: `sync_burst_sram`

## Requirements
- R1: A load cycle (`addr_load_n`=0) starts an access only if `sel1_n`=0, `sel2`=1 and `sel3_n`=0 at the edge. Any other load cycle is a deselect: it writes nothing and ends the active burst.
- R2: With `all_wr_n`=0 the captured cycle is a write to every lane, whatever `byte_en_n` and `lane_n` are.
- R3: With `all_wr_n`=1 and `byte_en_n`=0 the cycle is a write. Only the lanes with `lane_n[i]`=0 are written. Lane i is bits [9i+8:9i]. With both write strobes high the cycle is a read.
- R4: With `pipe_mode`=0, a read captured at edge e drives the addressed word on `dq_out` after edge e, with `dq_drive`=1. A captured write leaves `dq_drive`=0 in the next cycle.
- R5: With `pipe_mode`=1, a read captured at edge e is driven after edge e+1. It is only driven if the command captured at edge e+1 is not a deselect.
- R6: While a burst is active, a cycle with `addr_load_n`=1 and `adv_n`=0 moves to the next beat n = 1, 2, 3, 0, ... The word offset is (base+n) mod 4 when `linear_order`=1 and base XOR n when it is 0. Address bits above bit 1 never change.
- R7: While a burst is active, a cycle with both `addr_load_n` and `adv_n` high accesses the current address again.
- R8: `dq_drive` is 0 in the cycle right after a deselect is captured, in both read modes.
- R9: A read captured in the cycle after a write to the same address returns the newly written data.
- R10: `oe_n`=1 forces `dq_drive` to 0 at once, without waiting for a clock edge.
- R11: While `sleep`=1 no command is captured, memory and pipeline state are kept, and `dq_drive` is 0.
- R12: After reset the block is deselected and `dq_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pipe_mode | input | 1 | 1 selects pipelined reads, 0 selects flow-through |
| linear_order | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| addr_load_n | input | 1 | Load a new address and command, active low |
| adv_n | input | 1 | Advance the burst counter, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| byte_en_n | input | 1 | Write only the strobed lanes, active low |
| lane_n | input | LANES | Per-lane write strobes, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 9*LANES | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| dq_out | output | 9*LANES | Read data |
| dq_drive | output | 1 | High when the data pins are driven |

## Verification
The bench builds the block with ADDR_W=6 and LANES=2. This gives a 64-word array, small enough that every word is written and then read back in both read modes. All four lane-strobe patterns, the global-write override, all seven failing chip-select combinations, and all four burst start offsets in both orders are covered. A cycle-level reference model predicts `dq_drive` and `dq_out` after every edge. This exposes the turn-off cycle after deselects and writes, and the latency of each mode.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int LANE_W  = 9;
  localparam int BURST_W = 2;

  // offset of beat n within the aligned block
  function automatic logic [BURST_W-1:0] burst_ofs(input logic linear,
                                                   input logic [BURST_W-1:0] base,
                                                   input logic [BURST_W-1:0] n);
    return linear ? BURST_W'(base + n) : (base ^ n);
  endfunction

  function automatic logic is_write(input logic gw_n, input logic bw_n);
    return !gw_n || !bw_n;
  endfunction

  function automatic logic lane_written(input logic gw_n, input logic bw_n,
                                        input logic bx_n);
    return !gw_n || (!bw_n && !bx_n);
  endfunction
endpackage

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr import sbs_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              linear,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr
);
  logic [ADDR_W-1:0]  base_q, base_n;
  logic [BURST_W-1:0] cnt_q, cnt_n;

  always_comb begin
    base_n = load ? addr_in : base_q;
    if (load)      cnt_n = '0;
    else if (step) cnt_n = cnt_q + 1'b1;
    else           cnt_n = cnt_q;
  end

  assign nxt_addr = {base_n[ADDR_W-1:BURST_W], burst_ofs(linear, base_n[BURST_W-1:0], cnt_n)};
  assign cur_addr = {base_q[ADDR_W-1:BURST_W], burst_ofs(linear, base_q[BURST_W-1:0], cnt_q)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_n;
      cnt_q  <= cnt_n;
    end
  end

  AST_BLOCK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W])); // R6
endmodule

// File: rtl/sbs_array.sv
module sbs_array import sbs_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              wr_fire,
  input  logic              rd_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_mask,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_q
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              wp_q;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q;
  logic [LANES-1:0]  wm_q;

  // write is captured on one edge and retired on the next
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= 1'b0;
      wa_q <= '0;
      wd_q <= '0;
      wm_q <= '0;
      rd_q <= 1'b0;
    end else begin
      wp_q <= wr_fire;
      if (wr_fire) begin
        wa_q <= wr_addr;
        wd_q <= wr_data;
        wm_q <= wr_mask;
      end
      if (cap_en) rd_q <= rd_fire;
    end
  end

  always_ff @(posedge clk) begin
    if (wp_q)
      for (int i = 0; i < LANES; i++)
        if (wm_q[i]) mem[wa_q][i*LANE_W +: LANE_W] <= wd_q[i*LANE_W +: LANE_W];
  end

  assign rd_data = mem[rd_addr];

  AST_OP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_fire && wr_fire)); // R3
  AST_WR_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (wp_q && !rd_q)); // R9
endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              cap_en,
  input  logic              live,
  input  logic              oe_n,
  input  logic              rd_q,
  input  logic [DATA_W-1:0] ft_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive
);
  logic [DATA_W-1:0] pd_q;
  logic              rdp_q;
  logic              stage_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q  <= '0;
      rdp_q <= 1'b0;
    end else if (cap_en) begin
      pd_q  <= ft_data;
      rdp_q <= rd_q;
    end
  end

  assign stage_rd = pipe_mode ? rdp_q : rd_q;
  assign dq_drive = live && !oe_n && stage_rd;
  assign dq_out   = pipe_mode ? pd_q : ft_data;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram import sbs_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              linear_order,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              addr_load_n,
  input  logic              adv_n,
  input  logic              all_wr_n,
  input  logic              byte_en_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive
);
  // named command events
  logic cap_en, sel_ok, start, desel, cont, step, access, rd_fire, wr_fire;
  logic act_q;
  logic [LANES-1:0]  wmask;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  logic [DATA_W-1:0] ft_data;
  logic              rd_q;

  assign cap_en  = !sleep;
  assign sel_ok  = !sel1_n && sel2 && !sel3_n;
  assign start   = cap_en && !addr_load_n && sel_ok;
  assign desel   = cap_en && !addr_load_n && !sel_ok;
  assign cont    = cap_en && addr_load_n && act_q;
  assign step    = cont && !adv_n;
  assign access  = start || cont;
  assign wr_fire = access && is_write(all_wr_n, byte_en_n);
  assign rd_fire = access && !is_write(all_wr_n, byte_en_n);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wmask[g] = lane_written(all_wr_n, byte_en_n, lane_n[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     act_q <= 1'b0;
    else if (desel) act_q <= 1'b0;
    else if (start) act_q <= 1'b1;
  end

  sbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .linear(linear_order), .load(start), .step(step),
    .addr_in(addr), .cur_addr(cur_addr), .nxt_addr(nxt_addr)
  );

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_arr (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .wr_fire(wr_fire), .rd_fire(rd_fire),
    .wr_addr(nxt_addr), .wr_mask(wmask), .wr_data(wdata), .rd_addr(cur_addr),
    .rd_data(ft_data), .rd_q(rd_q)
  );

  sbs_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .cap_en(cap_en),
    .live(act_q && !sleep), .oe_n(oe_n), .rd_q(rd_q), .ft_data(ft_data),
    .dq_out(dq_out), .dq_drive(dq_drive)
  );

  AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !addr_load_n && !sel_ok) |=> !dq_drive); // R8
  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_drive); // R10
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_drive); // R11
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(cur_addr)); // R11
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && wr_fire) |=> !dq_drive); // R4
endmodule

// File: tb/sim_sync_burst_sram.sv
module sim_sync_burst_sram;
  localparam int AW = 6;
  localparam int LN = 2;
  localparam int DW = LN * 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pipe = 1'b0, lin = 1'b0;
  logic s1n = 1'b0, s2 = 1'b1, s3n = 1'b0;
  logic ld_n = 1'b1, adv = 1'b1, gw_n = 1'b1, bw_n = 1'b1;
  logic [LN-1:0] ln = '1;
  logic [AW-1:0] a = '0;
  logic [DW-1:0] d = '0;
  logic oe_n = 1'b0, slp = 1'b0;
  logic [DW-1:0] dq;
  logic drv;

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R12";

  always #10 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .LANES(LN)) u0 (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe), .linear_order(lin),
    .sel1_n(s1n), .sel2(s2), .sel3_n(s3n), .addr_load_n(ld_n), .adv_n(adv),
    .all_wr_n(gw_n), .byte_en_n(bw_n), .lane_n(ln), .addr(a), .wdata(d),
    .oe_n(oe_n), .sleep(slp), .dq_out(dq), .dq_drive(drv)
  );

  // reference model
  logic [DW-1:0] mm [64];
  bit m_act = 0, m_rd = 0, m_rdp = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0] m_cnt = '0;
  logic [DW-1:0] m_pd = '0;

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] o;
    if (lin) o = 2'((int'(m_base[1:0]) + int'(m_cnt)) % 4);
    else     o = m_base[1:0] ^ m_cnt;
    return {m_base[AW-1:2], o};
  endfunction

  function automatic logic [DW-1:0] pat(int x, int s);
    return DW'((x * 1237 + s * 40503) ^ 18'h2A5A5);
  endfunction

  task automatic chk(string r, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit acc, wr;
    if (slp) return;
    m_pd  = mm[m_addr()];
    m_rdp = m_rd;
    acc = 0;
    if (!ld_n) begin
      if (!s1n && s2 && !s3n) begin
        m_base = a; m_cnt = '0; m_act = 1; acc = 1;
      end else m_act = 0;
    end else if (m_act) begin
      acc = 1;
      if (!adv) m_cnt = m_cnt + 2'd1;
    end
    wr = !gw_n || !bw_n;
    m_rd = acc && !wr;
    if (acc && wr)
      for (int i = 0; i < LN; i++)
        if (!gw_n || (!bw_n && !ln[i])) mm[m_addr()][i*9 +: 9] = d[i*9 +: 9];
  endtask

  task automatic check_out();
    bit ed;
    ed = !slp && !oe_n && m_act && (pipe ? m_rdp : m_rd);
    chk({tag, " drive"}, DW'(drv), DW'(ed));
    if (ed && drv) chk({tag, " data"}, dq, pipe ? m_pd : mm[m_addr()]);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_out();
  endtask

  task automatic put(logic l, logic v, logic g, logic b, logic [LN-1:0] lanes,
                     logic [AW-1:0] ad, logic [DW-1:0] dd);
    ld_n = l; adv = v; gw_n = g; bw_n = b; ln = lanes; a = ad; d = dd;
  endtask

  task automatic rd(logic [AW-1:0] ad);
    put(0, 1, 1, 1, '1, ad, '0); tick();
  endtask
  task automatic wrg(logic [AW-1:0] ad, logic [DW-1:0] dd);
    put(0, 1, 0, 1, '1, ad, dd); tick();
  endtask
  task automatic wrb(logic [AW-1:0] ad, logic [LN-1:0] lanes, logic [DW-1:0] dd);
    put(0, 1, 1, 0, lanes, ad, dd); tick();
  endtask
  task automatic dsel();
    s1n = 1'b1; put(0, 1, 1, 1, '1, '0, '0); tick(); s1n = 1'b0;
  endtask
  task automatic advr();
    put(1, 0, 1, 1, '1, '0, '0); tick();
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R12"; chk("R12 reset drive", DW'(drv), '0);
    rst_n = 1'b1;
    put(1, 0, 1, 1, '1, '0, '0); tick(); tick();   // no burst active: nothing happens

    // fill the whole array with global writes, odd lane strobes to show the override
    tag = "R2";
    for (int x = 0; x < 64; x++) begin
      put(0, 1, 0, x[0], 2'(x), 6'(x), pat(x, 0)); tick();
    end
    dsel();

    // full readback in each read mode
    for (int pm = 0; pm < 2; pm++) begin
      pipe = pm[0];
      tag = pm ? "R5" : "R4";
      for (int x = 0; x < 64; x++) rd(6'(x));
      dsel(); dsel();
    end

    // per-lane byte writes, every strobe pattern, then readback
    pipe = 1'b0; tag = "R3";
    for (int x = 0; x < 16; x++) wrb(6'(x), 2'(x), pat(x, 1));
    put(0, 1, 1, 1, 2'b00, 6'd16, pat(16, 5)); tick();   // lane strobes alone: a read
    tag = "R2";
    for (int x = 17; x < 20; x++) begin put(0, 1, 0, 0, 2'(x), 6'(x), pat(x, 2)); tick(); end
    dsel();
    for (int pm = 0; pm < 2; pm++) begin
      pipe = pm[0]; tag = "R3";
      for (int x = 0; x < 20; x++) rd(6'(x));
      dsel();
    end

    // failing chip selects never write
    pipe = 1'b0; tag = "R1";
    for (int c = 0; c < 8; c++) begin
      if (c == 3'b010) continue;
      {s1n, s2, s3n} = 3'(c);
      put(0, 1, 0, 1, '1, 6'd40, pat(c, 7)); tick();
      s1n = 1'b0; s2 = 1'b1; s3n = 1'b0;
      rd(6'd40);
    end
    dsel();

    // bursts: both modes, both orders, every start offset, one wrap beat
    tag = "R6";
    for (int pm = 0; pm < 2; pm++)
      for (int lo = 0; lo < 2; lo++)
        for (int b = 0; b < 4; b++) begin
          pipe = pm[0]; lin = lo[0];
          rd(6'(32 + b));
          repeat (4) advr();
          dsel();
        end

    // burst write in linear order then read back
    lin = 1'b1; pipe = 1'b0;
    wrg(6'd26, pat(26, 3));
    for (int k = 1; k < 4; k++) begin put(1, 0, 0, 1, '1, '0, pat(k, 4)); tick(); end
    dsel();
    for (int x = 24; x < 28; x++) rd(6'(x));
    dsel();

    // suspended burst repeats the address
    tag = "R7";
    for (int pm = 0; pm < 2; pm++) begin
      pipe = pm[0];
      rd(6'd45); advr();
      put(1, 1, 1, 1, '1, '0, '0); tick(); tick();
      advr(); advr(); dsel();
    end

    // single-cycle deselect
    tag = "R8";
    for (int pm = 0; pm < 2; pm++) begin
      pipe = pm[0];
      rd(6'd5); dsel(); rd(6'd6); rd(6'd7); dsel(); dsel();
    end

    // write then immediate read
    tag = "R9";
    for (int pm = 0; pm < 2; pm++) begin
      pipe = pm[0];
      wrg(6'd50, pat(50, 8 + pm)); rd(6'd50); rd(6'd50);
      wrb(6'd51, 2'b10, pat(51, 11 + pm)); rd(6'd51); rd(6'd51);
      dsel();
    end

    // asynchronous output enable
    tag = "R10";
    pipe = 1'b1;
    rd(6'd3); rd(6'd4);
    chk("R10 driven before", DW'(drv), DW'(1));
    oe_n = 1'b1; #2;
    chk("R10 oe off", DW'(drv), '0);
    oe_n = 1'b0; #2;
    chk("R10 oe on", DW'(drv), DW'(1));
    chk("R10 data", dq, mm[3]);
    dsel();

    // sleep keeps memory and ignores commands
    tag = "R11";
    pipe = 1'b0;
    rd(6'd10);
    slp = 1'b1; #2;
    chk("R11 sleep off", DW'(drv), '0);
    wrg(6'd10, pat(10, 99));
    s1n = 1'b1; put(0, 1, 1, 1, '1, '0, '0); tick(); s1n = 1'b0;
    slp = 1'b0; #2;
    chk("R11 wake drive", DW'(drv), DW'(1));
    chk("R11 wake data", dq, mm[10]);
    dsel(); rd(6'd10); dsel();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule